// File: doc/BRIEF.md
# Interrupt and Reset Sequencer

This block decides when a processor core must leave normal execution to run a reset, non-maskable interrupt or maskable interrupt sequence, and then steps that sequence. The two interrupt lines are sampled on the phase-2 strobe. A decision is made only in a phase-2 cycle where the core flags the last cycle of an instruction, and service begins on the following phase-1 strobe. A falling edge on the non-maskable line is held in a latch until its service starts. The maskable line is a level, and it is honoured only while the core's interrupt-disable flag is clear.

An interrupt sequence asks the core for three stack pushes through a request/acknowledge handshake. The sequencer then orders the mask flag set and presents two vector addresses, low byte first, one machine cycle each. The reset pin must be seen low on two phase-2 samples before it takes effect. While it is low, writes are blocked. Its release starts six phase-1 cycles of initialisation, followed by the reset vector fetch with the mask-set order and no pushes. The core watches `svc_req_o` to know when to hand its bus and sequencing over.

Top module: `irq_rst_seq`

## Requirements
- R1: The maskable line (active low) starts a service only if it is low at a phase-2 strobe that has the end-of-instruction strobe high and the interrupt-disable flag clear.
- R2: A high-to-low change of the non-maskable line between two phase-2 samples starts a service whatever the disable flag is. A line that stays low does not start a second service.
- R3: A non-maskable edge seen in any phase-2 sample stays pending until its own service starts, even if the line returns high and the instruction ends later.
- R4: A service asks for exactly three pushes in order, with `push_sel_o` 0 then 1 then 2. It advances one push per `push_ack_i` cycle, and `set_i_o` is high in the vector-low cycle that follows.
- R5: Vectors are read low address first, each for one machine cycle (phase-1 to phase-1): maskable FFFE/FFFF, non-maskable FFFA/FFFB, reset FFFC/FFFD.
- R6: Priority is reset over non-maskable over maskable. A valid reset aborts a service in progress.
- R7: `wr_inhibit_o` is high whenever the reset pin is low, and stays high until the pin's release is sampled.
- R8: The reset pin takes effect only after two consecutive low phase-2 samples. A shorter low pulse leaves the sequencer idle.
- R9: After a valid reset release, six phase-1 strobes pass with no fetch. The reset vector is read on the sixth, with `set_i_o` high and no push requests.
- R10: `svc_req_o` rises and `src_o` shows the source right after the deciding phase-2 strobe. The push phase starts at the next phase-1 strobe. The `src_o` codes are 0 none, 1 maskable, 2 non-maskable, 3 reset.
- R11: After block reset (`rst_ni` low) the sequencer is in reset hold, with `src_o`=3 and `svc_req_o`=1. The first phase-2 strobe with the reset pin high starts the reset sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| res_n_i | input | 1 | Processor reset pin, active low |
| nmi_n_i | input | 1 | Non-maskable interrupt line, falling edge |
| irq_n_i | input | 1 | Maskable interrupt line, active low level |
| i_flag_i | input | 1 | Interrupt-disable flag from the core |
| phi1_en_i | input | 1 | Phase-1 strobe, one clock per machine cycle |
| phi2_en_i | input | 1 | Phase-2 strobe, one clock per machine cycle |
| insn_end_i | input | 1 | Last cycle of the current instruction |
| push_ack_i | input | 1 | Core has done the requested push |
| svc_req_o | output | 1 | Sequencer owns the core |
| src_o | output | 2 | Source being serviced |
| push_req_o | output | 1 | Push request |
| push_sel_o | output | 2 | Push item: 0 PC high, 1 PC low, 2 status |
| vec_rd_o | output | 1 | Vector fetch cycle |
| vec_addr_o | output | 16 | Vector fetch address |
| set_i_o | output | 1 | Set the interrupt-disable flag |
| wr_inhibit_o | output | 1 | Block bus writes |

## Verification
`src_o` and `svc_req_o` change on the clock edge of the deciding phase-2 strobe, so the bench reads them at the falling edge that follows. Push requests start one phase-1 strobe later. Each push selector step appears one clock after its acknowledge. Each vector address is due one clock after the phase-1 edge that opens its cycle. `wr_inhibit_o` follows the reset pin with no register, so it is read one time unit after the pin changes. Reset hold is entered on the first clock after the second low phase-2 sample, and the bench checks it after the phase-1 strobe that follows. Every check is made at a falling edge, before the next strobe is driven.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_IRQ = 2'd1, SRC_NMI = 2'd2, SRC_RST = 2'd3} src_e;
  typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_INIT, ST_ARM, ST_PUSH, ST_VLO, ST_VHI} st_e;
endpackage

// File: rtl/seq_line_sampler.sv
`timescale 1ns/1ps
module seq_line_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi2_en_i,
  input  logic nmi_n_i,
  input  logic irq_n_i,
  input  logic nmi_clr_i,
  output logic nmi_hit_o,
  output logic irq_hit_o
);
  logic nmi_q, pend_q, edge_now;

  assign edge_now = phi2_en_i & nmi_q & ~nmi_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (phi2_en_i) nmi_q <= nmi_n_i;
      if (nmi_clr_i)     pend_q <= 1'b0;
      else if (edge_now) pend_q <= 1'b1;
    end
  end

  // an edge in the deciding sample counts at once
  assign nmi_hit_o = pend_q | edge_now;
  assign irq_hit_o = phi2_en_i & ~irq_n_i;
endmodule

// File: rtl/seq_rst_timer.sv
`timescale 1ns/1ps
module seq_rst_timer #(
  parameter int HOLD_MIN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phi2_en_i,
  input  logic res_n_i,
  output logic hold_ok_o,
  output logic start_o
);
  localparam int LO_W = $clog2(HOLD_MIN + 1);
  localparam logic [LO_W-1:0] LO_MAX = LO_W'(HOLD_MIN);

  logic            res_q;
  logic [LO_W-1:0] lo_cnt_q;

  assign hold_ok_o = (lo_cnt_q == LO_MAX);
  assign start_o   = phi2_en_i & res_n_i & ~res_q & hold_ok_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q    <= 1'b0;
      lo_cnt_q <= LO_MAX;
    end else if (phi2_en_i) begin
      res_q <= res_n_i;
      if (!res_n_i) begin
        if (lo_cnt_q != LO_MAX) lo_cnt_q <= lo_cnt_q + LO_W'(1);
      end else begin
        lo_cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/seq_fsm.sv
`timescale 1ns/1ps
module seq_fsm
  import seq_pkg::*;
#(
  parameter int INIT_CYC = 6,
  parameter int PUSH_N   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      phi1_en_i,
  input  logic                      phi2_en_i,
  input  logic                      insn_end_i,
  input  logic                      i_flag_i,
  input  logic                      nmi_hit_i,
  input  logic                      irq_hit_i,
  input  logic                      hold_ok_i,
  input  logic                      rst_start_i,
  input  logic                      push_ack_i,
  output st_e                       state_o,
  output src_e                      src_o,
  output logic [$clog2(PUSH_N)-1:0] idx_o,
  output logic                      nmi_clr_o
);
  localparam int CNT_W = $clog2(INIT_CYC);
  localparam int SEL_W = $clog2(PUSH_N);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYC - 1);
  localparam logic [SEL_W-1:0] IDX_LAST = SEL_W'(PUSH_N - 1);

  st_e              st_q, st_d;
  src_e             src_q, src_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    src_d = src_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (rst_start_i) begin
      st_d  = ST_INIT;
      src_d = SRC_RST;
      cnt_d = '0;
    end else if (hold_ok_i) begin
      st_d  = ST_HOLD;
      src_d = SRC_RST;
    end else begin
      unique case (st_q)
        ST_IDLE: if (phi2_en_i && insn_end_i) begin
          if (nmi_hit_i) begin
            st_d  = ST_ARM;
            src_d = SRC_NMI;
          end else if (irq_hit_i && !i_flag_i) begin
            st_d  = ST_ARM;
            src_d = SRC_IRQ;
          end
        end
        ST_HOLD: ;
        ST_INIT: if (phi1_en_i) begin
          if (cnt_q == CNT_LAST) st_d = ST_VLO;
          else                   cnt_d = cnt_q + CNT_W'(1);
        end
        ST_ARM: if (phi1_en_i) begin
          st_d  = ST_PUSH;
          idx_d = '0;
        end
        ST_PUSH: if (push_ack_i) begin
          if (idx_q == IDX_LAST) st_d = ST_VLO;
          else                   idx_d = idx_q + SEL_W'(1);
        end
        ST_VLO: if (phi1_en_i) st_d = ST_VHI;
        ST_VHI: if (phi1_en_i) begin
          st_d  = ST_IDLE;
          src_d = SRC_NONE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HOLD;
      src_q <= SRC_RST;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      src_q <= src_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign state_o   = st_q;
  assign src_o     = src_q;
  assign idx_o     = idx_q;
  assign nmi_clr_o = (st_q == ST_HOLD) |
                     ((st_q == ST_ARM) & phi1_en_i & (src_q == SRC_NMI));
endmodule

// File: rtl/irq_rst_seq.sv
`timescale 1ns/1ps
module irq_rst_seq
  import seq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int INIT_CYC = 6,
  parameter int HOLD_MIN = 2,
  parameter int PUSH_N   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      res_n_i,
  input  logic                      nmi_n_i,
  input  logic                      irq_n_i,
  input  logic                      i_flag_i,
  input  logic                      phi1_en_i,
  input  logic                      phi2_en_i,
  input  logic                      insn_end_i,
  input  logic                      push_ack_i,
  output logic                      svc_req_o,
  output logic [1:0]                src_o,
  output logic                      push_req_o,
  output logic [$clog2(PUSH_N)-1:0] push_sel_o,
  output logic                      vec_rd_o,
  output logic [ADDR_W-1:0]         vec_addr_o,
  output logic                      set_i_o,
  output logic                      wr_inhibit_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] VEC_IRQ  = TOP_ADDR - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] VEC_RST  = TOP_ADDR - ADDR_W'(3);
  localparam logic [ADDR_W-1:0] VEC_NMI  = TOP_ADDR - ADDR_W'(5);

  logic nmi_hit, irq_hit, nmi_clr, hold_ok, rst_start;
  st_e  state;
  src_e src;
  logic [ADDR_W-2:0] base_hi;

  seq_line_sampler u_lines (
    .clk_i, .rst_ni, .phi2_en_i, .nmi_n_i, .irq_n_i,
    .nmi_clr_i(nmi_clr), .nmi_hit_o(nmi_hit), .irq_hit_o(irq_hit)
  );

  seq_rst_timer #(.HOLD_MIN(HOLD_MIN)) u_rst (
    .clk_i, .rst_ni, .phi2_en_i, .res_n_i,
    .hold_ok_o(hold_ok), .start_o(rst_start)
  );

  seq_fsm #(.INIT_CYC(INIT_CYC), .PUSH_N(PUSH_N)) u_fsm (
    .clk_i, .rst_ni, .phi1_en_i, .phi2_en_i, .insn_end_i, .i_flag_i,
    .nmi_hit_i(nmi_hit), .irq_hit_i(irq_hit), .hold_ok_i(hold_ok),
    .rst_start_i(rst_start), .push_ack_i, .state_o(state), .src_o(src),
    .idx_o(push_sel_o), .nmi_clr_o(nmi_clr)
  );

  always_comb begin
    unique case (src)
      SRC_NMI: base_hi = VEC_NMI[ADDR_W-1:1];
      SRC_RST: base_hi = VEC_RST[ADDR_W-1:1];
      default: base_hi = VEC_IRQ[ADDR_W-1:1];
    endcase
  end

  assign svc_req_o    = (state != ST_IDLE);
  assign src_o        = src;
  assign push_req_o   = (state == ST_PUSH);
  assign vec_rd_o     = (state == ST_VLO) | (state == ST_VHI);
  assign vec_addr_o   = vec_rd_o ? {base_hi, state == ST_VHI} : '0;
  assign set_i_o      = (state == ST_VLO);
  assign wr_inhibit_o = ~res_n_i | (state == ST_HOLD);
endmodule

// File: rtl/seq_checker.sv
`timescale 1ns/1ps
module seq_checker #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              res_n_i,
  input logic              irq_n_i,
  input logic              i_flag_i,
  input logic              phi2_en_i,
  input logic              insn_end_i,
  input logic              push_ack_i,
  input logic              svc_req_o,
  input logic [1:0]        src_o,
  input logic              push_req_o,
  input logic [SEL_W-1:0]  push_sel_o,
  input logic              vec_rd_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic              set_i_o,
  input logic              wr_inhibit_o
);
  a_r1_irq_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(svc_req_o) && src_o == 2'd1 |-> $past(!i_flag_i && !irq_n_i));

  a_r10_start_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(svc_req_o) && src_o != 2'd3 |-> $past(phi2_en_i && insn_end_i));

  a_r4_sel_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_req_o && $past(push_req_o) && !$past(push_ack_i) |-> push_sel_o == $past(push_sel_o));

  a_r4_mask_after_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(push_req_o) |-> set_i_o || src_o == 2'd3);

  a_r4_set_on_low_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i_o |-> vec_rd_o && !vec_addr_o[0]);

  a_r9_no_push_on_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_req_o |-> src_o == 2'd1 || src_o == 2'd2);

  a_r5_low_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_rd_o) |-> !vec_addr_o[0]);

  a_r5_vec_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_o |-> &vec_addr_o[ADDR_W-1:3]);

  a_r7_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_n_i |-> wr_inhibit_o);
endmodule

bind irq_rst_seq seq_checker #(.ADDR_W(ADDR_W), .SEL_W($clog2(PUSH_N))) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .res_n_i(res_n_i), .irq_n_i(irq_n_i),
  .i_flag_i(i_flag_i), .phi2_en_i(phi2_en_i), .insn_end_i(insn_end_i),
  .push_ack_i(push_ack_i), .svc_req_o(svc_req_o), .src_o(src_o),
  .push_req_o(push_req_o), .push_sel_o(push_sel_o), .vec_rd_o(vec_rd_o),
  .vec_addr_o(vec_addr_o), .set_i_o(set_i_o), .wr_inhibit_o(wr_inhibit_o)
);

// File: tb/sim_irq_rst_seq.sv
`timescale 1ns/1ps
module sim_irq_rst_seq;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic res_n = 1'b1, nmi_n = 1'b1, irq_n = 1'b1, i_flag = 1'b0;
  logic phi1 = 1'b0, phi2 = 1'b0, insn_end = 1'b0, push_ack = 1'b0;
  logic svc_req, push_req, vec_rd, set_i, wr_inh;
  logic [1:0] src, push_sel;
  logic [15:0] vec_addr;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_rst_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .res_n_i(res_n), .nmi_n_i(nmi_n), .irq_n_i(irq_n),
    .i_flag_i(i_flag), .phi1_en_i(phi1), .phi2_en_i(phi2), .insn_end_i(insn_end),
    .push_ack_i(push_ack), .svc_req_o(svc_req), .src_o(src), .push_req_o(push_req),
    .push_sel_o(push_sel), .vec_rd_o(vec_rd), .vec_addr_o(vec_addr), .set_i_o(set_i),
    .wr_inhibit_o(wr_inh)
  );

  // {nmi falls, irq low, i_flag, expected src}
  localparam logic [4:0] TBL [0:6] = '{
    5'b0_1_0_01, 5'b0_1_1_00, 5'b1_0_1_10, 5'b1_1_0_10,
    5'b0_0_0_00, 5'b1_1_1_10, 5'b0_1_0_01
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ph1();
    phi1 = 1'b1;
    @(negedge clk);
    phi1 = 1'b0;
  endtask

  task automatic ph2();
    phi2 = 1'b1;
    @(negedge clk);
    phi2 = 1'b0;
  endtask

  function automatic logic [15:0] base_of(input logic [1:0] s);
    case (s)
      2'd1: return 16'hFFFE;
      2'd2: return 16'hFFFA;
      default: return 16'hFFFC;
    endcase
  endfunction

  // starts in reset hold with res_n already high; ends idle after a phase 1
  task automatic rst_seq(input string tag);
    ph2();
    check({tag, " R9 init svc"}, svc_req, 1);
    check({tag, " R9 init src"}, src, 3);
    for (int i = 0; i < 5; i++) begin
      ph1();
      check({tag, " R9 no fetch in init"}, vec_rd, 0);
      ph2();
    end
    ph1();
    check({tag, " R9 fetch on sixth"}, vec_rd, 1);
    check({tag, " R5 reset low addr"}, vec_addr, 16'hFFFC);
    check({tag, " R9 set mask"}, set_i, 1);
    check({tag, " R9 no push"}, push_req, 0);
    ph2();
    ph1();
    check({tag, " R5 reset high addr"}, vec_addr, 16'hFFFD);
    check({tag, " R5 mask cmd ends"}, set_i, 0);
    ph2();
    ph1();
    check({tag, " R5 back idle"}, svc_req, 0);
    check({tag, " R5 src none"}, src, 0);
  endtask

  // starts in ARM after the deciding phase 2; ends idle after a phase 1
  task automatic serve(input logic [1:0] s, input string tag);
    ph1();
    for (int k = 0; k < 3; k++) begin
      check({tag, " R4 push req"}, push_req, 1);
      check({tag, " R4 push order"}, push_sel, k);
      push_ack = 1'b1;
      @(negedge clk);
      push_ack = 1'b0;
    end
    check({tag, " R4 pushes done"}, push_req, 0);
    check({tag, " R4 mask set"}, set_i, 1);
    check({tag, " R5 low vector"}, vec_addr, base_of(s));
    ph2();
    check({tag, " R5 low held"}, vec_addr, base_of(s));
    ph1();
    check({tag, " R5 high vector"}, vec_addr, base_of(s) | 16'h1);
    ph2();
    ph1();
    check({tag, " R5 idle"}, svc_req, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R11 reset hold svc", svc_req, 1);
    check("R11 reset src", src, 3);
    check("R11 hold inhibits", wr_inh, 1);
    check("R11 no fetch", vec_rd, 0);
    rst_seq("R11 power-on");

    // vector table
    for (int t = 0; t < 7; t++) begin
      nmi_n = ~TBL[t][4];
      irq_n = ~TBL[t][3];
      i_flag = TBL[t][2];
      insn_end = 1'b1;
      ph2();
      insn_end = 1'b0;
      check($sformatf("R10 R6 tbl%0d src", t), src, TBL[t][1:0]);
      check($sformatf("R1 R2 tbl%0d svc", t), svc_req, TBL[t][1:0] != 0);
      if (TBL[t][1:0] != 0) serve(TBL[t][1:0], $sformatf("tbl%0d", t));
      else begin
        ph1();
        check($sformatf("R1 tbl%0d stays idle", t), svc_req, 0);
      end
      nmi_n = 1'b1;
      irq_n = 1'b1;
      i_flag = 1'b0;
      ph2();
      ph1();
    end

    // R1/R10: no decision without end strobe, none on phase 1
    irq_n = 1'b0;
    ph2();
    check("R1 no end no service", svc_req, 0);
    insn_end = 1'b1;
    ph1();
    check("R10 phase1 not sampled", svc_req, 0);
    ph2();
    insn_end = 1'b0;
    check("R10 irq decided", src, 1);
    serve(2'd1, "R10 irq");
    irq_n = 1'b1;
    ph2();
    ph1();

    // R3: edge mid-instruction survives line return
    nmi_n = 1'b0;
    ph2();
    check("R3 not yet", svc_req, 0);
    ph1();
    nmi_n = 1'b1;
    ph2();
    ph1();
    check("R3 still idle", svc_req, 0);
    insn_end = 1'b1;
    i_flag = 1'b1;
    ph2();
    insn_end = 1'b0;
    check("R3 pending nmi taken", src, 2);
    serve(2'd2, "R3 nmi");
    i_flag = 1'b0;

    // R2: held-low line does not retrigger
    nmi_n = 1'b0;
    insn_end = 1'b1;
    ph2();
    insn_end = 1'b0;
    check("R2 edge taken", src, 2);
    serve(2'd2, "R2 nmi");
    insn_end = 1'b1;
    ph2();
    insn_end = 1'b0;
    check("R2 held low ignored", svc_req, 0);
    ph1();
    nmi_n = 1'b1;
    ph2();
    ph1();

    // R8: short reset pulse ignored
    res_n = 1'b0;
    #1;
    check("R7 inhibit on low", wr_inh, 1);
    @(negedge clk);
    ph2();
    res_n = 1'b1;
    #1;
    check("R7 inhibit released", wr_inh, 0);
    @(negedge clk);
    ph1();
    ph2();
    ph1();
    check("R8 short pulse idle", svc_req, 0);
    check("R8 short pulse src", src, 0);

    // R6: reset aborts an interrupt in progress
    irq_n = 1'b0;
    insn_end = 1'b1;
    ph2();
    insn_end = 1'b0;
    ph1();
    check("R6 irq pushing", push_req, 1);
    irq_n = 1'b1;
    res_n = 1'b0;
    #1;
    check("R7 inhibit mid service", wr_inh, 1);
    @(negedge clk);
    ph2();
    ph1();
    check("R8 one sample no hold", src, 1);
    ph2();
    ph1();
    check("R6 reset takes over", src, 3);
    check("R6 push dropped", push_req, 0);
    check("R8 hold inhibits", wr_inh, 1);
    res_n = 1'b1;
    rst_seq("R6 abort");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule